// File: doc/BRIEF.md
# Low-Power Opportunity Request Controller

This block sits on the memory-controller side of the link to the PHY and runs the handshake that offers the PHY a chance to drop into a low-power state. When the controller reports that no commands are pending, the block raises a request and presents a 4-bit wakeup code that selects one of sixteen wakeup times. It then gives the PHY a bounded window to accept the offer. If the PHY accepts, the controller may later ask for a deeper sleep by strobing in a larger code. When work arrives again the request is withdrawn, and the block waits for the PHY to release its acknowledge.

While the request is up, and until the acknowledge has cleared after exit, the block holds off command issue. A 16-entry programmable table turns each wakeup code into a cycle budget for the exit watchdog. Two kinds of misbehaviour set a sticky error flag: an acknowledge seen after the offer was declined, and an acknowledge that stays high beyond the budget of the final code.

Top module: `lp_opp_ctrl`

## Requirements
- R1: The request rises one cycle after `ctl_idle_i` is sampled high with the block idle. `cmd_hold_o` is high in every cycle in which `lp_req_o` is high.
- R2: The 4-bit `wake_code_o` takes the value of `entry_code_i` sampled at the clock edge that starts the request.
- R3: Until the acknowledge is accepted or the response window closes, `wake_code_o` stays constant, and deepen strobes have no effect on it.
- R4: Once the acknowledge is accepted, a strobe on `deeper_vld_i` whose `deeper_code_i` is larger than the current code replaces the code from the next cycle. A strobe with a smaller or equal value is ignored. A strobe in the same cycle as the exit decision is also ignored.
- R5: An acknowledge counts only if it is sampled high during the first T_RESP cycles of the request. Otherwise the offer is declined, and any acknowledge sampled high while declined sets `proto_err_o` in the next cycle.
- R6: The request stays high for at least T_RESP cycles, even if `ctl_idle_i` falls sooner. Once that minimum is met, it falls one cycle after `ctl_idle_i` is sampled low.
- R7: Count the first cycle with the request low as exit cycle 0. If the acknowledge is still sampled high in exit cycle N, where N is the table entry for the final code, `proto_err_o` rises in the next cycle.
- R8: After exit, `cmd_hold_o` falls one cycle after the acknowledge is first sampled low, and never before.
- R9: Table entry i resets to (i+1)*STEP. A write with `wt_wr_i` high stores `wt_val_i` at index `wt_idx_i` from the next cycle. An exit that loads the budget in the same cycle as a write uses the old entry.
- R10: `proto_err_o` stays high once set until reset.
- R11: After reset, `lp_req_o`, `cmd_hold_o`, `proto_err_o` and `wake_code_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_idle_i | input | 1 | Controller has no pending commands |
| entry_code_i | input | 4 | Wakeup code offered when the request starts |
| deeper_vld_i | input | 1 | Strobe asking for a new wakeup code |
| deeper_code_i | input | 4 | Requested wakeup code |
| wt_wr_i | input | 1 | Wakeup table write enable |
| wt_idx_i | input | 4 | Wakeup table write index |
| wt_val_i | input | CW | Wakeup table write value, in cycles |
| phy_ack_i | input | 1 | Acknowledge from the PHY |
| lp_req_o | output | 1 | Low-power opportunity request to the PHY |
| wake_code_o | output | 4 | Wakeup code presented to the PHY |
| cmd_hold_o | output | 1 | Blocks command issue |
| proto_err_o | output | 1 | Sticky handshake error |

## Verification
Two events can land on the same edge: a deepen strobe and the exit decision, when `ctl_idle_i` falls in the same cycle that a larger code is strobed. The bench sets up exactly this case. It checks that the code does not change and that the exit budget comes from the old code: an acknowledge held for one cycle more than that budget must raise the error. A behavioural model also runs alongside on every clock. It covers table writes that coincide with budget loads, and acknowledges that arrive on the last cycle of the response window.

// File: rtl/lp_opp_pkg.sv
package lp_opp_pkg;
  localparam int CODE_W    = 4;
  localparam int NUM_CODES = 1 << CODE_W;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_GRANT = 3'd2,
    ST_DECL  = 3'd3,
    ST_WAKE  = 3'd4
  } lp_st_e;
endpackage

// File: rtl/lp_rst_sync.sv
module lp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/lp_wake_table.sv
module lp_wake_table
  import lp_opp_pkg::*;
#(
  parameter int CW   = 8,
  parameter int STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_idx,
  input  logic [CW-1:0]     wr_val,
  input  logic [CODE_W-1:0] rd_idx,
  output logic [CW-1:0]     rd_val
);
  logic [CW-1:0] ent_q [NUM_CODES];

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_ent
    localparam logic [CW-1:0] RST_VAL = CW'((i + 1) * STEP);
    logic          we;
    logic [CW-1:0] ent_d;

    assign we = wr_en && (wr_idx == CODE_W'(i));

    always_comb begin
      ent_d = ent_q[i];
      if (we) ent_d = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ent_q[i] <= RST_VAL;
      else if (we) ent_q[i] <= ent_d;
    end
  end

  assign rd_val = ent_q[rd_idx];
endmodule

// File: rtl/lp_resp_timer.sv
module lp_resp_timer #(
  parameter int T_RESP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int RW   = (T_RESP > 1) ? $clog2(T_RESP) : 1;
  localparam int LAST = T_RESP - 1;

  logic [RW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done   = (cnt_q == RW'(LAST));
  assign cnt_en = start || (run && !done);

  always_comb begin
    cnt_d = cnt_q;
    if (start)    cnt_d = '0;
    else if (run) cnt_d = cnt_q + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_RC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= RW'(LAST)); // R6
endmodule

// File: rtl/lp_exit_wdog.sv
module lp_exit_wdog #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic          expired
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load || (run && !expired);

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (run) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_WD_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && !expired) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R7
endmodule

// File: rtl/lp_code_guard.sv
module lp_code_guard
  import lp_opp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] load_val,
  input  logic              up_ok,
  input  logic              up_vld,
  input  logic [CODE_W-1:0] up_val,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] code_q, code_d;
  logic              raise, code_en;

  assign raise   = up_ok && up_vld && (up_val > code_q);
  assign code_en = load || raise;

  always_comb begin
    code_d = code_q;
    if (load)       code_d = load_val;
    else if (raise) code_d = up_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  assign code = code_q;

  AST_CODE_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (code_q >= $past(code_q))); // R4
endmodule

// File: rtl/lp_opp_ctrl.sv
module lp_opp_ctrl
  import lp_opp_pkg::*;
#(
  parameter int T_RESP = 4,
  parameter int CW     = 8,
  parameter int STEP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_idle_i,
  input  logic [CODE_W-1:0] entry_code_i,
  input  logic              deeper_vld_i,
  input  logic [CODE_W-1:0] deeper_code_i,
  input  logic              wt_wr_i,
  input  logic [CODE_W-1:0] wt_idx_i,
  input  logic [CW-1:0]     wt_val_i,
  input  logic              phy_ack_i,
  output logic              lp_req_o,
  output logic [CODE_W-1:0] wake_code_o,
  output logic              cmd_hold_o,
  output logic              proto_err_o
);
  logic              rst_s_n;
  lp_st_e            st_q, st_d;
  logic              err_q, err_d, err_en;
  logic              rc_done, wd_expired;
  logic              start_req, exit_go, up_ok, wd_load, wd_run;
  logic [CODE_W-1:0] code;
  logic [CW-1:0]     budget;

  lp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  assign start_req = (st_q == ST_IDLE) && ctl_idle_i;
  assign exit_go   = !ctl_idle_i && rc_done &&
                     ((st_q == ST_GRANT) || (st_q == ST_DECL));
  assign up_ok     = (st_q == ST_GRANT) && !exit_go;
  assign wd_load   = exit_go;
  assign wd_run    = (st_q == ST_WAKE) && phy_ack_i;

  lp_resp_timer #(.T_RESP(T_RESP)) u_rt (
    .clk   (clk),
    .rst_n (rst_s_n),
    .start (start_req),
    .run   (lp_req_o),
    .done  (rc_done)
  );

  lp_code_guard u_cg (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load     (start_req),
    .load_val (entry_code_i),
    .up_ok    (up_ok),
    .up_vld   (deeper_vld_i),
    .up_val   (deeper_code_i),
    .code     (code)
  );

  lp_wake_table #(.CW(CW), .STEP(STEP)) u_tbl (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .wr_en  (wt_wr_i),
    .wr_idx (wt_idx_i),
    .wr_val (wt_val_i),
    .rd_idx (code),
    .rd_val (budget)
  );

  lp_exit_wdog #(.CW(CW)) u_wd (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load     (wd_load),
    .load_val (budget),
    .run      (wd_run),
    .expired  (wd_expired)
  );

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (ctl_idle_i) st_d = ST_WAIT;
      ST_WAIT: begin
        if (phy_ack_i)    st_d = ST_GRANT;
        else if (rc_done) st_d = ST_DECL;
      end
      ST_GRANT: if (exit_go) st_d = ST_WAKE;
      ST_DECL:  if (exit_go) st_d = ST_WAKE;
      ST_WAKE:  if (!phy_ack_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    err_d  = err_q;
    err_en = 1'b0;
    if ((st_q == ST_DECL) && phy_ack_i) begin
      err_d  = 1'b1;
      err_en = 1'b1;
    end
    if ((st_q == ST_WAKE) && phy_ack_i && wd_expired) begin
      err_d  = 1'b1;
      err_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (err_en) err_q <= err_d;
    end
  end

  assign lp_req_o    = (st_q == ST_WAIT) || (st_q == ST_GRANT) || (st_q == ST_DECL);
  assign cmd_hold_o  = (st_q != ST_IDLE);
  assign wake_code_o = code;
  assign proto_err_o = err_q;

  AST_REQ_BLOCKS: assert property (@(posedge clk) disable iff (!rst_s_n)
    lp_req_o |-> cmd_hold_o); // R1
  AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((st_q == ST_WAIT) && $past(st_q == ST_WAIT)) |-> $stable(wake_code_o)); // R3
  AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(lp_req_o) |-> $past(rc_done)); // R6
  AST_UNBLOCK_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(cmd_hold_o) |-> !$past(phy_ack_i)); // R8
  AST_LATE_ACK: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((st_q == ST_DECL) && phy_ack_i) |=> proto_err_o); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_s_n)
    proto_err_o |=> proto_err_o); // R10
endmodule

// File: tb/sim_lp_opp_ctrl.sv
module sim_lp_opp_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int T_RESP     = 4;
  localparam int CW         = 8;
  localparam int STEP       = 2;

  logic clk, rst_n;
  logic ctl_idle_i, deeper_vld_i, wt_wr_i, phy_ack_i;
  logic [3:0] entry_code_i, deeper_code_i, wt_idx_i;
  logic [CW-1:0] wt_val_i;
  logic lp_req_o, cmd_hold_o, proto_err_o;
  logic [3:0] wake_code_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int m_st, m_rc, m_wc, m_code, m_err, s1, s2;
  int m_tbl [16];

  lp_opp_ctrl #(.T_RESP(T_RESP), .CW(CW), .STEP(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_idle_i(ctl_idle_i),
    .entry_code_i(entry_code_i), .deeper_vld_i(deeper_vld_i),
    .deeper_code_i(deeper_code_i), .wt_wr_i(wt_wr_i), .wt_idx_i(wt_idx_i),
    .wt_val_i(wt_val_i), .phy_ack_i(phy_ack_i), .lp_req_o(lp_req_o),
    .wake_code_o(wake_code_o), .cmd_hold_o(cmd_hold_o),
    .proto_err_o(proto_err_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  // model: states 0 idle, 1 waiting, 2 granted, 3 declined, 4 waking
  task automatic model_edge();
    int st = m_st, rc = m_rc, wc = m_wc, code = m_code, err = m_err;
    bool_exit: begin end
    if (!s2 || !rst_n) begin
      st = 0; rc = 0; wc = 0; code = 0; err = 0;
      for (int i = 0; i < 16; i++) m_tbl[i] = (i + 1) * STEP;
    end else begin
      int is_req = (m_st >= 1 && m_st <= 3);
      int go = (!ctl_idle_i && m_rc == T_RESP - 1 && (m_st == 2 || m_st == 3));
      if (m_st == 0 && ctl_idle_i) begin st = 1; rc = 0; code = entry_code_i; end
      else if (is_req && m_rc < T_RESP - 1) rc = m_rc + 1;
      case (m_st)
        1: if (phy_ack_i) st = 2; else if (m_rc == T_RESP - 1) st = 3;
        2: begin
          if (!go && deeper_vld_i && deeper_code_i > m_code) code = deeper_code_i;
          if (go) begin st = 4; wc = m_tbl[m_code]; end
        end
        3: begin
          if (phy_ack_i) err = 1;
          if (go) begin st = 4; wc = m_tbl[m_code]; end
        end
        4: if (!phy_ack_i) st = 0;
           else if (m_wc == 0) err = 1;
           else wc = m_wc - 1;
        default: ;
      endcase
      if (wt_wr_i) m_tbl[wt_idx_i] = wt_val_i;
    end
    m_st = st; m_rc = rc; m_wc = wc; m_code = code; m_err = err;
    if (!rst_n) begin s1 = 0; s2 = 0; end
    else begin s2 = s1; s1 = 1; end
  endtask

  task automatic compare();
    if (!rst_n) return;
    chk("R6 model req",  lp_req_o,    (m_st >= 1 && m_st <= 3));
    chk("R4 model code", wake_code_o, m_code);
    chk("R8 model hold", cmd_hold_o,  (m_st != 0));
    chk("R7 model err",  proto_err_o, m_err);
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ctl_idle_i = 0; deeper_vld_i = 0; wt_wr_i = 0; phy_ack_i = 0;
    entry_code_i = 0; deeper_code_i = 0; wt_idx_i = 0; wt_val_i = 0;
    step(2);
    rst_n = 1'b1;
    step(3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    s1 = 0; s2 = 0; m_st = 0; m_rc = 0; m_wc = 0; m_code = 0; m_err = 0;
    for (int i = 0; i < 16; i++) m_tbl[i] = (i + 1) * STEP;
    @(negedge clk);
    do_reset();
    // R11 reset state
    chk("R11 req",  lp_req_o, 0);
    chk("R11 hold", cmd_hold_o, 0);
    chk("R11 err",  proto_err_o, 0);
    chk("R11 code", wake_code_o, 0);

    // normal entry, frozen code, deepen, exit
    entry_code_i = 3; ctl_idle_i = 1; step();
    chk("R1 req rises", lp_req_o, 1);
    chk("R1 hold with req", cmd_hold_o, 1);
    chk("R2 code captured", wake_code_o, 3);
    entry_code_i = 0; deeper_vld_i = 1; deeper_code_i = 9; step();
    chk("R3 code frozen", wake_code_o, 3);
    deeper_vld_i = 0; phy_ack_i = 1; step();
    deeper_vld_i = 1; deeper_code_i = 7; step();
    chk("R4 code raised", wake_code_o, 7);
    deeper_code_i = 5; step();
    chk("R4 smaller ignored", wake_code_o, 7);
    deeper_vld_i = 0; ctl_idle_i = 0; step();
    chk("R6 req dropped", lp_req_o, 0);
    chk("R8 hold while ack", cmd_hold_o, 1);
    step(2);
    phy_ack_i = 0; step();
    chk("R8 hold released", cmd_hold_o, 0);
    chk("R7 no error", proto_err_o, 0);

    // minimum request length
    begin
      int n = 1;
      entry_code_i = 0; ctl_idle_i = 1; step();
      ctl_idle_i = 0; phy_ack_i = 1; step();
      while (lp_req_o && n < 20) begin n++; step(); end
      chk("R6 min length", n, T_RESP);
      phy_ack_i = 0; step();
      chk("R8 idle again", cmd_hold_o, 0);
    end

    // declined offer, late acknowledge
    ctl_idle_i = 1; step(5);
    chk("R5 declined req held", lp_req_o, 1);
    chk("R5 no error yet", proto_err_o, 0);
    phy_ack_i = 1; step();
    chk("R5 late ack error", proto_err_o, 1);
    phy_ack_i = 0; ctl_idle_i = 0; step(2);
    chk("R10 error sticky", proto_err_o, 1);
    chk("R8 released after decline", cmd_hold_o, 0);

    // programmed entry, exit boundary
    do_reset();
    wt_wr_i = 1; wt_idx_i = 2; wt_val_i = 5; step();
    wt_wr_i = 0;
    for (int r = 0; r < 2; r++) begin
      entry_code_i = 2; ctl_idle_i = 1; step();
      phy_ack_i = 1; step(4);
      ctl_idle_i = 0; step();
      step(5 + r);
      chk(r == 0 ? "R9 written entry in time" : "R7 exit overrun",
          proto_err_o, r);
      phy_ack_i = 0; step();
    end

    // deepen strobe on the exit edge, default table entry
    do_reset();
    entry_code_i = 1; ctl_idle_i = 1; step();
    phy_ack_i = 1; step(4);
    deeper_vld_i = 1; deeper_code_i = 6; ctl_idle_i = 0; step();
    deeper_vld_i = 0;
    chk("R4 strobe on exit ignored", wake_code_o, 1);
    step(4);
    chk("R9 default entry in time", proto_err_o, 0);
    step();
    chk("R9 default entry overrun", proto_err_o, 1);
    phy_ack_i = 0; step(2);
    chk("R10 error held", proto_err_o, 1);

    summary();
  end
endmodule